// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block writes one 32-bit word into a one-time-programmable fuse array. When a request arrives it first reads the word that the array already holds. It then clears every requested bit that is already blown, so no fuse is burned a second time. The remaining word goes into a shift register and is walked one bit per slot, from the least significant bit up. A burn strobe is issued only for bits that hold 1. Each burn strobe and the read strobe are preceded by a relax pad. The strobe widths and the pad length come from a packed timing word that is captured at the start of the request.

Once the last bit has been handled, busy drops. The sequencer then waits a fixed quiet interval, set by a parameter in clock cycles, and marks completion with a one-cycle done pulse. New requests are taken only while the sequencer is idle. Requests that arrive while busy, during the quiet interval or in the done cycle are dropped. Turning clock frequency into timing values is the job of the command logic that feeds this block.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset, busy, done, the read strobe and the burn strobe are all 0.
- R2: A start is accepted only in the idle state. The address, data and timing are captured at acceptance, and the fuse address output holds that captured address throughout the operation. A start during an operation has no effect.
- R3: An operation begins with a relax pad of R cycles (busy high, no strobes), followed by the read strobe held for D cycles at the captured address.
- R4: The word to burn equals the requested data AND NOT the word read from the array. Bits already blown are never strobed.
- R5: Bits are handled in order from 0 to 31. Each bit takes one decision cycle. A 0 bit gets no strobe. A 1 bit gets a burn strobe, and the bit index output shows that bit's position.
- R6: Every burn strobe is preceded by R relax cycles and is held high for exactly P consecutive cycles.
- R7: The data register shifts right with zero fill once per bit. During the burn of bit i it holds the masked word shifted right by i.
- R8: The timing word places P in bits [11:0], R in bits [15:12] and D in bits [21:16]. All other bits have no effect.
- R9: A timing field of zero acts as one cycle.
- R10: Busy falls after the last bit. QUIET_CYC cycles then pass with busy and done both low, followed by exactly one cycle with done high, and then the sequencer returns to idle.
- R11: The read strobe and the burn strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to program one word |
| addr_i | input | ADDR_W | Target fuse word address |
| wdata_i | input | WORD_W | Bits requested to be blown |
| timing_i | input | 32 | Packed timing word (program, relax and read counts) |
| fuse_rd_data_i | input | WORD_W | Current contents of the addressed fuse word |
| fuse_addr_o | output | ADDR_W | Address presented to the fuse array |
| fuse_rd_stb_o | output | 1 | Read strobe to the fuse array |
| fuse_burn_stb_o | output | 1 | Burn strobe for the selected bit |
| fuse_bit_o | output | IDX_W | Bit position being handled |
| shift_data_o | output | WORD_W | Current content of the data shift register |
| busy_o | output | 1 | Read or program phase in progress |
| done_o | output | 1 | One-cycle completion pulse after the quiet interval |

## Verification
On every cycle, the assertions check that the two strobes never overlap and that busy and done never overlap. They also check that done lasts only one cycle, that a burn strobe occurs only while the low data bit is 1, that the register shifts right with zero fill when a burn ends, and that the fuse address stays fixed during an operation. The exact phase lengths, the read-before-burn ordering, the masking against already blown bits, the decoding of the timing fields, the clamping of zero fields and the dropping of late starts can only be shown by the bench scenarios. There, a behavioural per-cycle model and a fuse array that needs a full-width strobe to set a bit are compared against the outputs.

// File: rtl/fuse_seq_pkg.sv
// Shared types and field layout for the fuse programming sequencer.
// Assumes a 32-bit packed timing word with fixed field positions.
package fuse_seq_pkg;
    localparam int PROG_W    = 12;
    localparam int RELAX_W   = 4;
    localparam int READ_W    = 6;
    localparam int PROG_LSB  = 0;
    localparam int RELAX_LSB = 12;
    localparam int READ_LSB  = 16;
    localparam int TIMING_W  = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_RLX,
        ST_RD_STB,
        ST_BIT,
        ST_PRE,
        ST_BURN,
        ST_QUIET,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [PROG_W-1:0]  prog;
        logic [RELAX_W-1:0] relax;
        logic [READ_W-1:0]  rd;
    } fuse_timing_t;
endpackage

// File: rtl/fuse_timing_decode.sv
// Splits the packed timing word into its three counts and raises any zero
// count to one cycle. Purely combinational; bits outside the fields are unused.
module fuse_timing_decode
    import fuse_seq_pkg::*;
(
    input  logic [TIMING_W-1:0] timing_raw,
    output fuse_timing_t        timing_eff
);
    logic [PROG_W-1:0]  prog_f;
    logic [RELAX_W-1:0] relax_f;
    logic [READ_W-1:0]  rd_f;
    logic               unused_timing_bits;

    assign prog_f  = timing_raw[PROG_LSB  +: PROG_W];
    assign relax_f = timing_raw[RELAX_LSB +: RELAX_W];
    assign rd_f    = timing_raw[READ_LSB  +: READ_W];
    assign unused_timing_bits = ^timing_raw[TIMING_W-1:READ_LSB+READ_W];

    // Clamp each count to a minimum of one clock.
    always_comb begin
        timing_eff.prog  = (prog_f  == '0) ? PROG_W'(1)  : prog_f;
        timing_eff.relax = (relax_f == '0) ? RELAX_W'(1) : relax_f;
        timing_eff.rd    = (rd_f    == '0) ? READ_W'(1)  : rd_f;
    end
endmodule

// File: rtl/fuse_down_counter.sv
// Loadable down counter used to time every phase. It stops at zero.
// Assumes the caller loads (length - 1) so that a phase lasts `length` cycles.
module fuse_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0);
endmodule

// File: rtl/fuse_shift_reg.sv
// Data register for the word being programmed. It is loaded at request
// acceptance, masked once with the read-back word, then shifted right with
// zero fill. Priority: load, then mask, then shift.
module fuse_shift_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              mask_en,
    input  logic [WORD_W-1:0] blown_bits,
    input  logic              shift_en,
    output logic [WORD_W-1:0] q
);
    // Update the data register for the current operation step.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load)     q <= load_val;
        else if (mask_en)  q <= q & ~blown_bits;
        else if (shift_en) q <= q >> 1;
    end

    a_r4_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && !load) |=> (q & $past(blown_bits)) == '0);
endmodule

// File: rtl/fuse_prog_seq.sv
// Top of the fuse programming sequencer. It reads the target word, masks
// already blown bits, then walks the word bit 0 upward and issues a burn
// strobe for each remaining 1. Ends with a quiet interval and a done pulse.
// Assumes the fuse array returns read data combinationally for fuse_addr_o.
module fuse_prog_seq
    import fuse_seq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 7,
    parameter int QUIET_CYC = 200,
    localparam int IDX_W    = $clog2(WORD_W),
    localparam int QW       = $clog2(QUIET_CYC + 1),
    localparam int CNT_W    = (QW > PROG_W) ? QW : PROG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    input  logic [TIMING_W-1:0] timing_i,
    input  logic [WORD_W-1:0]   fuse_rd_data_i,
    output logic [ADDR_W-1:0]   fuse_addr_o,
    output logic                fuse_rd_stb_o,
    output logic                fuse_burn_stb_o,
    output logic [IDX_W-1:0]    fuse_bit_o,
    output logic [WORD_W-1:0]   shift_data_o,
    output logic                busy_o,
    output logic                done_o
);
    seq_state_e        state_q, state_d;
    fuse_timing_t      dec_t, tim_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              idx_last;
    logic              cnt_load, cnt_exp;
    logic [CNT_W-1:0]  cnt_val;
    logic              sh_load, sh_mask, sh_shift;
    logic              idx_clr, idx_inc, accept;

    fuse_timing_decode u_dec (
        .timing_raw (timing_i),
        .timing_eff (dec_t)
    );

    fuse_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_exp)
    );

    fuse_shift_reg #(.WORD_W(WORD_W)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_val   (wdata_i),
        .mask_en    (sh_mask),
        .blown_bits (fuse_rd_data_i),
        .shift_en   (sh_shift),
        .q          (shift_data_o)
    );

    assign idx_last = (idx_q == IDX_W'(WORD_W - 1));

    // Sequence control: choose next phase and the counter load for it.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        sh_load  = 1'b0;
        sh_mask  = 1'b0;
        sh_shift = 1'b0;
        idx_clr  = 1'b0;
        idx_inc  = 1'b0;
        accept   = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                accept   = 1'b1;
                sh_load  = 1'b1;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(dec_t.relax) - CNT_W'(1);
                state_d  = ST_RD_RLX;
            end
            ST_RD_RLX: if (cnt_exp) begin
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(tim_q.rd) - CNT_W'(1);
                state_d  = ST_RD_STB;
            end
            ST_RD_STB: if (cnt_exp) begin
                sh_mask = 1'b1;
                idx_clr = 1'b1;
                state_d = ST_BIT;
            end
            ST_BIT: begin
                if (shift_data_o[0]) begin
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(tim_q.relax) - CNT_W'(1);
                    state_d  = ST_PRE;
                end else begin
                    sh_shift = 1'b1;
                    if (idx_last) begin
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(QUIET_CYC - 1);
                        state_d  = ST_QUIET;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
            end
            ST_PRE: if (cnt_exp) begin
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(tim_q.prog) - CNT_W'(1);
                state_d  = ST_BURN;
            end
            ST_BURN: if (cnt_exp) begin
                sh_shift = 1'b1;
                if (idx_last) begin
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(QUIET_CYC - 1);
                    state_d  = ST_QUIET;
                end else begin
                    idx_inc = 1'b1;
                    state_d = ST_BIT;
                end
            end
            ST_QUIET: if (cnt_exp) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, captured request fields and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tim_q   <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tim_q  <= dec_t;
                addr_q <= addr_i;
            end
            if (idx_clr)      idx_q <= '0;
            else if (idx_inc) idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign fuse_addr_o     = addr_q;
    assign fuse_bit_o      = idx_q;
    assign fuse_rd_stb_o   = (state_q == ST_RD_STB);
    assign fuse_burn_stb_o = (state_q == ST_BURN);
    assign done_o          = (state_q == ST_DONE);
    assign busy_o          = (state_q != ST_IDLE) && (state_q != ST_QUIET) &&
                             (state_q != ST_DONE);

    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd_stb_o && fuse_burn_stb_o));
    a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_burn_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_burn_stb_o |-> shift_data_o[0]);
    a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_burn_stb_o) |-> shift_data_o == ($past(shift_data_o) >> 1));
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));
endmodule

// File: tb/fuse_prog_seq_tb_top.sv
// Bench: behavioural per-cycle reference model (expectation queue) plus a
// fuse array model that sets a bit only after a full-width burn strobe.
module fuse_prog_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QUIET      = 5;

    typedef struct packed {
        logic        busy;
        logic        rd;
        logic        burn;
        logic        done;
        logic [4:0]  bidx;
        logic [31:0] sh;
        logic [6:0]  addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] timing_i = '0;
    logic [31:0] fuse_rd_data;
    logic [6:0]  fuse_addr;
    logic        rd_stb, burn_stb, busy, done;
    logic [4:0]  fuse_bit;
    logic [31:0] shift_data;

    logic [31:0] mem [0:127];
    exp_t        expq[$];
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;
    int          burn_run = 0;
    int          prog_need = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_prog_seq #(.WORD_W(32), .ADDR_W(7), .QUIET_CYC(QUIET)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .addr_i         (addr_i),
        .wdata_i        (wdata_i),
        .timing_i       (timing_i),
        .fuse_rd_data_i (fuse_rd_data),
        .fuse_addr_o    (fuse_addr),
        .fuse_rd_stb_o  (rd_stb),
        .fuse_burn_stb_o(burn_stb),
        .fuse_bit_o     (fuse_bit),
        .shift_data_o   (shift_data),
        .busy_o         (busy),
        .done_o         (done)
    );

    assign fuse_rd_data = mem[fuse_addr];

    // Fuse array model: a bit sets once strobed for prog_need cycles in a row.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= '0;
            mem[4]   <= 32'h0000_F00F;
            burn_run <= 0;
        end else if (burn_stb) begin
            burn_run <= burn_run + 1;
            if (burn_run + 1 >= prog_need) mem[fuse_addr][fuse_bit] <= 1'b1;
        end else begin
            burn_run <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Expected cycle sequence of one accepted request (R3..R10, R8/R9 decode).
    task automatic push_op(input logic [6:0] a, input logic [31:0] wd,
                           input logic [31:0] t);
        int p, r, d;
        logic [31:0] m;
        exp_t e;
        p = clamp1(int'(t[11:0]));
        r = clamp1(int'(t[15:12]));
        d = clamp1(int'(t[21:16]));
        prog_need = p;
        m = wd & ~mem[a];
        e = '0; e.addr = a; e.busy = 1'b1;
        for (int k = 0; k < r; k++) expq.push_back(e);
        e.rd = 1'b1;
        for (int k = 0; k < d; k++) expq.push_back(e);
        e.rd = 1'b0;
        for (int i = 0; i < 32; i++) begin
            expq.push_back(e);
            if (m[i]) begin
                for (int k = 0; k < r; k++) expq.push_back(e);
                e.burn = 1'b1; e.bidx = 5'(i); e.sh = m >> i;
                for (int k = 0; k < p; k++) expq.push_back(e);
                e.burn = 1'b0; e.bidx = '0; e.sh = '0;
            end
        end
        e = '0; e.addr = a;
        for (int k = 0; k < QUIET; k++) expq.push_back(e);
        e.done = 1'b1;
        expq.push_back(e);
    endtask

    // Per-cycle comparison against the model; the model accepts starts only when idle.
    always @(negedge clk) begin
        exp_t e;
        bit   popped;
        if (rst_n) begin
            popped = 1'b0;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                popped = 1'b1;
            end else begin
                e = '0;
            end
            check(busy === e.busy, "R2", "busy", 32'(busy), 32'(e.busy));
            check(rd_stb === e.rd, "R3", "read strobe", 32'(rd_stb), 32'(e.rd));
            check(burn_stb === e.burn, "R5", "burn strobe", 32'(burn_stb), 32'(e.burn));
            check(done === e.done, "R10", "done", 32'(done), 32'(e.done));
            check(!(rd_stb && burn_stb), "R11", "strobe overlap", 32'(burn_stb), 32'h0);
            if (e.burn) begin
                check(fuse_bit === e.bidx, "R5", "bit index", 32'(fuse_bit), 32'(e.bidx));
                check(shift_data === e.sh, "R7", "shift data", shift_data, e.sh);
            end
            if (e.rd || e.burn)
                check(fuse_addr === e.addr, "R2", "fuse address", 32'(fuse_addr), 32'(e.addr));
            if (!popped && start_i) push_op(addr_i, wdata_i, timing_i);
        end
    end

    task automatic wait_done();
        do @(posedge clk); while (!done);
        repeat (3) @(posedge clk);
    endtask

    task automatic run_op(input logic [6:0] a, input logic [31:0] wd,
                          input logic [31:0] t);
        @(posedge clk); #1;
        start_i = 1'b1; addr_i = a; wdata_i = wd; timing_i = t;
        @(posedge clk); #1;
        start_i = 1'b0;
        wait_done();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=<60000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: idle outputs after reset
        check(!busy && !done && !rd_stb && !burn_stb, "R1", "reset outputs",
              {28'h0, busy, done, rd_stb, burn_stb}, 32'h0);

        // R8: fields prog=3 relax=1 read=2
        run_op(7'd2, 32'h0000_00A5, 32'h0002_1003);
        // R4: second write to same word burns only the new bits
        run_op(7'd2, 32'h0000_00FF, 32'h0003_2002);
        // R9 and R8: zero fields, junk in unused upper bits, preexisting fuses
        run_op(7'd4, 32'h0001_FF1F, 32'hF0C0_0000);

        // R2: a start raised mid-operation is dropped
        @(posedge clk); #1;
        start_i = 1'b1; addr_i = 7'd5; wdata_i = 32'h8000_0003; timing_i = 32'h0003_2004;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (20) @(posedge clk);
        #1 start_i = 1'b1; addr_i = 7'd6; wdata_i = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        start_i = 1'b0;
        wait_done();

        // R5: all-zero word gives only skip slots
        run_op(7'd7, 32'h0000_0000, 32'h0001_1002);

        // R10: start held through quiet and done is taken again only from idle
        @(posedge clk); #1;
        start_i = 1'b1; addr_i = 7'd1; wdata_i = 32'h0000_0100; timing_i = 32'h0001_1002;
        do @(posedge clk); while (!done);
        do @(posedge clk); while (!done);
        #1 start_i = 1'b0;
        repeat (4) @(posedge clk);

        // R4 and R6: final array contents (full-width strobes needed to set bits)
        check(mem[2] === 32'h0000_00FF, "R4", "word 2", mem[2], 32'h0000_00FF);
        check(mem[4] === 32'h0001_FF1F, "R6", "word 4", mem[4], 32'h0001_FF1F);
        check(mem[5] === 32'h8000_0003, "R6", "word 5", mem[5], 32'h8000_0003);
        check(mem[6] === 32'h0000_0000, "R2", "word 6 untouched", mem[6], 32'h0);
        check(mem[7] === 32'h0000_0000, "R5", "word 7 untouched", mem[7], 32'h0);
        check(mem[1] === 32'h0000_0100, "R10", "word 1", mem[1], 32'h0000_0100);
        check(expq.size() == 0, "R10", "model queue drained", 32'(expq.size()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule